// File: doc/BRIEF.md
# Nonvolatile State Save/Restore Sequencer

This block is a clocked power-management controller for a logic island whose flip-flops carry a nonvolatile shadow element. It watches a single asynchronous energy-available flag from a supply monitor and drives four control strobes shared by every shadow flip-flop: a power-gate strobe, a latch-disable strobe, an equalize strobe and an enable for the nonvolatile rail. It also drives a clock-enable that freezes or resumes the user logic, and a flag that tells the supply side when power may be removed.

When the energy flag drops, the controller freezes the user logic and steps the strobes through a save sequence. It then waits a fixed drain interval and asserts the safe-to-power-off flag. When the flag returns, it runs the matching restore sequence and re-enables the user logic. Every milestone is a fixed cycle count, so the strobe timing stays the same at every clock rate and every output changes only on a controller clock edge. A save or restore that has begun always runs to its end. A flag change seen during a sequence is acted on only once the sequence is finished.

The cycle counts are parameters. The defaults give the end of save on cycle 8, power-off on cycle 10, data valid on cycle 6 of a restore and resume on cycle 10.

Top module: `nvstate_seq`

## Requirements
- R1: After reset the controller is in the powered-off state (state code 0), with power-gate, latch-disable, equalize and power-safe at 1, rail enable and user clock-enable at 0, and both done pulses at 0.
- R2: The energy flag passes through two flip-flops. Cycle j of a sequence is the j-th rising edge after the edge on which the second flip-flop takes the new level. Nothing at the outputs changes on cycles j = -1 or j = 0.
- R3: In the running state (state code 2), power-gate, latch-disable, equalize and power-safe are 0, and rail enable and user clock-enable are 1.
- R4: A save (state code 3) clears the user clock-enable on cycle 1. On cycle 2 power-gate goes to 1 and rail enable to 0, and latch-disable follows on cycle 4. On cycle 8 equalize goes to 1 and the save-done output gives a one-cycle pulse.
- R5: On cycle 10 of a save the controller returns to the powered-off state, with power-safe at 1 and all strobes as in R1.
- R6: A restore (state code 1) drops power-gate on cycle 1 and equalize on cycle 2. Rail enable rises on cycle 3, and latch-disable drops on cycle 6, when the restored data is valid.
- R7: On cycle 10 of a restore the controller enters the running state, and the restore-done output gives a one-cycle pulse.
- R8: If the flag falls during a restore, the restore still completes on its cycle 10. The save then begins at once, with its cycle numbering counted from that edge.
- R9: If the flag rises during a save, the save still reaches power-off on its cycle 10. The restore then begins at once, with its cycle numbering counted from that edge.
- R10: While power-gate is 1, the user clock-enable and rail enable are 0. Latch-disable rises only while power-gate is already 1, and equalize rises only while latch-disable is already 1. Power-safe is 1 only while all three strobes are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock, running before the energy flag first rises |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| energy_ok_i | input | 1 | Asynchronous energy-available flag |
| pgate_o | output | 1 | Power-gate strobe to the shadow flip-flops |
| ldis_o | output | 1 | Latch-disable strobe |
| eqz_o | output | 1 | Equalize strobe |
| nvrail_en_o | output | 1 | Enable of the nonvolatile rail |
| uclk_en_o | output | 1 | Clock-enable of the user logic |
| pwr_safe_o | output | 1 | Power may be removed |
| state_o | output | 2 | State code: 0 off, 1 restore, 2 run, 3 save |
| save_done_o | output | 1 | One-cycle pulse at the end of a save |
| restore_done_o | output | 1 | One-cycle pulse when the user logic resumes |

## Verification
On every cycle the assertions check the strobe orderings and exclusions: power-gate cuts both the user clock and the rail, latch-disable rises only under power-gate, equalize rises only under latch-disable, and power-gate is the first strobe to fall. They also check that the done pulses last one cycle, that the sequence counter steps as it should and that the synchronizer only passes on its previous stage. The exact cycle of every milestone, the two-flop input latency, and the way a flag change during a sequence is deferred can be shown only by the bench. It sweeps the offset of that change across every cycle of both sequences and compares all outputs on each cycle with a timeline computed from the requirements.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  typedef enum logic [1:0] {
    ST_OFF     = 2'd0,
    ST_RESTORE = 2'd1,
    ST_RUN     = 2'd2,
    ST_SAVE    = 2'd3
  } nvs_state_e;

  typedef struct packed {
    logic pgate;
    logic ldis;
    logic eqz;
    logic rail_en;
    logic uclk_en;
    logic pwr_safe;
  } nvs_strobes_t;

  function automatic int nvs_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nvs_sync.sv
module nvs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic stage_d;
    if (g == 0) begin : g_first
      assign stage_d = async_i;
    end else begin : g_next
      assign stage_d = chain_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain_q[g] <= 1'b0;
      end else begin
        chain_q[g] <= stage_d;
      end
    end
  end

  assign sync_o = chain_q[STAGES-1];

  // R2: the output only ever takes the value the previous stage held
  p_sync_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sync_o) |-> (sync_o == $past(chain_q[STAGES-2])));

endmodule

// File: rtl/nvs_timer.sv
module nvs_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (start_i) begin
      cnt_d = CNT_W'(1);
    end else if (step_i) begin
      cnt_d = cnt_q + CNT_W'(1);
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  // R4: a stepping sequence advances by exactly one per cycle
  p_cnt_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !start_i) |=> (cnt_o == $past(cnt_o) + CNT_W'(1)));

  // R8: a fresh sequence always begins at cycle one
  p_cnt_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (cnt_o == CNT_W'(1)));

endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
  import nvs_pkg::*;
#(
  parameter int EQ_AT     = 8,
  parameter int SAFE_GAP  = 2,
  parameter int RS_RESUME = 10,
  parameter int CNT_W     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flag_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             start_o,
  output logic             step_o,
  output nvs_state_e       state_o,
  output logic             save_done_o,
  output logic             restore_done_o
);

  localparam logic [CNT_W-1:0] C_SV_END = CNT_W'(EQ_AT + SAFE_GAP - 1);
  localparam logic [CNT_W-1:0] C_EQ_PRE = CNT_W'(EQ_AT - 1);
  localparam logic [CNT_W-1:0] C_RS_END = CNT_W'(RS_RESUME - 1);

  nvs_state_e state_q, state_d;
  logic       sdone_q, sdone_d;
  logic       rdone_q, rdone_d;

  // next-state process
  always_comb begin
    state_d = state_q;
    start_o = 1'b0;
    step_o  = 1'b0;
    unique case (state_q)
      ST_OFF: begin
        if (flag_i) begin
          state_d = ST_RESTORE;
          start_o = 1'b1;
        end
      end
      ST_RESTORE: begin
        if (cnt_i == C_RS_END) begin
          state_d = ST_RUN;
        end else begin
          step_o = 1'b1;
        end
      end
      ST_RUN: begin
        if (!flag_i) begin
          state_d = ST_SAVE;
          start_o = 1'b1;
        end
      end
      ST_SAVE: begin
        if (cnt_i == C_SV_END) begin
          state_d = ST_OFF;
        end else begin
          step_o = 1'b1;
        end
      end
      default: state_d = ST_OFF;
    endcase
  end

  assign sdone_d = (state_q == ST_SAVE)    && (cnt_i == C_EQ_PRE);
  assign rdone_d = (state_q == ST_RESTORE) && (cnt_i == C_RS_END);

  // register process
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      sdone_q <= 1'b0;
      rdone_q <= 1'b0;
    end else begin
      state_q <= state_d;
      sdone_q <= sdone_d;
      rdone_q <= rdone_d;
    end
  end

  assign state_o        = state_q;
  assign save_done_o    = sdone_q;
  assign restore_done_o = rdone_q;

  // R4: save completion is a single-cycle pulse inside the save
  p_save_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_done_o |=> !save_done_o);
  p_save_done_state_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_done_o |-> (state_o == ST_SAVE));

  // R7: resume pulse lasts one cycle and coincides with the first run cycle
  p_restore_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_done_o |=> !restore_done_o);
  p_restore_done_entry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_done_o |-> (state_o == ST_RUN && $past(state_o) == ST_RESTORE));

  // R8 / R9: a running sequence is never left except at its own end
  p_restore_no_abort_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_RESTORE) |=> (state_o == ST_RESTORE || state_o == ST_RUN));
  p_save_no_abort_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_SAVE) |=> (state_o == ST_SAVE || state_o == ST_OFF));

endmodule

// File: rtl/nvs_decode.sv
module nvs_decode
  import nvs_pkg::*;
#(
  parameter int PG_AT      = 2,
  parameter int LD_AT      = 4,
  parameter int EQ_AT      = 8,
  parameter int RS_EQ_OFF  = 2,
  parameter int RS_RAIL_ON = 3,
  parameter int RS_VALID   = 6,
  parameter int CNT_W      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  nvs_state_e       state_i,
  input  logic [CNT_W-1:0] cnt_i,
  output nvs_strobes_t     strb_o
);

  localparam logic [CNT_W-1:0] C_PG   = CNT_W'(PG_AT);
  localparam logic [CNT_W-1:0] C_LD   = CNT_W'(LD_AT);
  localparam logic [CNT_W-1:0] C_EQ   = CNT_W'(EQ_AT);
  localparam logic [CNT_W-1:0] C_REQ  = CNT_W'(RS_EQ_OFF);
  localparam logic [CNT_W-1:0] C_RAIL = CNT_W'(RS_RAIL_ON);
  localparam logic [CNT_W-1:0] C_VAL  = CNT_W'(RS_VALID);

  always_comb begin
    strb_o = '0;
    unique case (state_i)
      ST_OFF: begin
        strb_o.pgate    = 1'b1;
        strb_o.ldis     = 1'b1;
        strb_o.eqz      = 1'b1;
        strb_o.pwr_safe = 1'b1;
      end
      ST_RESTORE: begin
        strb_o.eqz     = (cnt_i <  C_REQ);
        strb_o.rail_en = (cnt_i >= C_RAIL);
        strb_o.ldis    = (cnt_i <  C_VAL);
      end
      ST_RUN: begin
        strb_o.rail_en = 1'b1;
        strb_o.uclk_en = 1'b1;
      end
      ST_SAVE: begin
        strb_o.pgate   = (cnt_i >= C_PG);
        strb_o.rail_en = (cnt_i <  C_PG);
        strb_o.ldis    = (cnt_i >= C_LD);
        strb_o.eqz     = (cnt_i >= C_EQ);
      end
      default: strb_o = '0;
    endcase
  end

  // R10: power-gate excludes the user clock and the rail
  p_pg_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_o.pgate |-> (!strb_o.uclk_en && !strb_o.rail_en));
  // R10: latch-disable rises only under an already-raised power-gate
  p_ld_after_pg_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strb_o.ldis) |-> $past(strb_o.pgate));
  // R10: equalize rises only under an already-raised latch-disable
  p_eq_after_ld_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strb_o.eqz) |-> $past(strb_o.ldis));
  // R5: power may be removed only with all three strobes raised
  p_safe_strobes_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_o.pwr_safe |-> (strb_o.pgate && strb_o.ldis && strb_o.eqz));
  // R4: the user clock is already frozen when power-gate rises
  p_freeze_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strb_o.pgate) |-> !$past(strb_o.uclk_en));
  // R6: power-gate is the first strobe to fall on restore
  p_pg_falls_first_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strb_o.pgate) |-> (strb_o.ldis && strb_o.eqz && !strb_o.rail_en));

endmodule

// File: rtl/nvstate_seq.sv
module nvstate_seq
  import nvs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PG_AT       = 2,
  parameter int LD_AT       = 4,
  parameter int EQ_AT       = 8,
  parameter int SAFE_GAP    = 2,
  parameter int RS_EQ_OFF   = 2,
  parameter int RS_RAIL_ON  = 3,
  parameter int RS_VALID    = 6,
  parameter int RS_RESUME   = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       energy_ok_i,
  output logic       pgate_o,
  output logic       ldis_o,
  output logic       eqz_o,
  output logic       nvrail_en_o,
  output logic       uclk_en_o,
  output logic       pwr_safe_o,
  output logic [1:0] state_o,
  output logic       save_done_o,
  output logic       restore_done_o
);

  localparam int LAST_CYC = nvs_max(EQ_AT + SAFE_GAP, RS_RESUME);
  localparam int CNT_W    = $clog2(LAST_CYC + 1);

  logic             flag_s;
  logic             start_w;
  logic             step_w;
  logic [CNT_W-1:0] cnt_w;
  nvs_state_e       state_w;
  nvs_strobes_t     strb_w;

  nvs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (energy_ok_i),
    .sync_o  (flag_s)
  );

  nvs_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_w),
    .step_i  (step_w),
    .cnt_o   (cnt_w)
  );

  nvs_ctrl #(
    .EQ_AT     (EQ_AT),
    .SAFE_GAP  (SAFE_GAP),
    .RS_RESUME (RS_RESUME),
    .CNT_W     (CNT_W)
  ) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .flag_i         (flag_s),
    .cnt_i          (cnt_w),
    .start_o        (start_w),
    .step_o         (step_w),
    .state_o        (state_w),
    .save_done_o    (save_done_o),
    .restore_done_o (restore_done_o)
  );

  nvs_decode #(
    .PG_AT      (PG_AT),
    .LD_AT      (LD_AT),
    .EQ_AT      (EQ_AT),
    .RS_EQ_OFF  (RS_EQ_OFF),
    .RS_RAIL_ON (RS_RAIL_ON),
    .RS_VALID   (RS_VALID),
    .CNT_W      (CNT_W)
  ) u_decode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_i (state_w),
    .cnt_i   (cnt_w),
    .strb_o  (strb_w)
  );

  assign pgate_o     = strb_w.pgate;
  assign ldis_o      = strb_w.ldis;
  assign eqz_o       = strb_w.eqz;
  assign nvrail_en_o = strb_w.rail_en;
  assign uclk_en_o   = strb_w.uclk_en;
  assign pwr_safe_o  = strb_w.pwr_safe;
  assign state_o     = state_w;

  // R3: the user logic runs only in the running state with a live rail
  p_run_strobes_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uclk_en_o |-> (state_o == 2'd2 && nvrail_en_o && !pgate_o && !ldis_o && !eqz_o));

endmodule

// File: tb/nvstate_seq_tb_top.sv
module nvstate_seq_tb_top;

  logic       clk;
  logic       rst_n;
  logic       energy;
  logic       pgate, ldis, eqz, rail, uclk, safe, sdone, rdone;
  logic [1:0] st;
  int         checks;
  int         errors;
  bit         finished;

  nvstate_seq dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .energy_ok_i    (energy),
    .pgate_o        (pgate),
    .ldis_o         (ldis),
    .eqz_o          (eqz),
    .nvrail_en_o    (rail),
    .uclk_en_o      (uclk),
    .pwr_safe_o     (safe),
    .state_o        (st),
    .save_done_o    (sdone),
    .restore_done_o (rdone)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // vector layout: {state[1:0], pgate, ldis, eqz, rail, uclk, safe, sdone, rdone}
  function automatic logic [9:0] v_off();
    return {2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
  endfunction

  function automatic logic [9:0] v_run(input logic rd);
    return {2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, rd};
  endfunction

  // R6/R7 restore timeline
  function automatic logic [9:0] r_exp(input int j);
    if (j <= 0) return v_off();
    if (j >= 10) return v_run(j == 10);
    return {2'd1, 1'b0, (j < 6), (j < 2), (j >= 3), 1'b0, 1'b0, 1'b0, 1'b0};
  endfunction

  // R4/R5 save timeline
  function automatic logic [9:0] s_exp(input int j);
    if (j <= 0) return v_run(1'b0);
    if (j >= 10) return v_off();
    return {2'd3, (j >= 2), (j >= 4), (j >= 8), (j < 2), 1'b0, 1'b0, (j == 8), 1'b0};
  endfunction

  // kind 0: restore first, kind 1: save first; d > 0 adds a flag change (R8/R9)
  function automatic logic [9:0] exp_at(input int kind, input int d, input int j);
    if (kind == 0) return (d > 0 && j > 10) ? s_exp(j - 10) : r_exp(j);
    return (d > 0 && j > 10) ? r_exp(j - 10) : s_exp(j);
  endfunction

  function automatic logic [9:0] act_vec();
    return {st, pgate, ldis, eqz, rail, uclk, safe, sdone, rdone};
  endfunction

  task automatic check_vec(input string tag, input int j, input logic [9:0] exp_v);
    logic [9:0] a;
    a = act_vec();
    checks++;
    if (a !== exp_v) begin
      errors++;
      $display("FAIL %s cycle %0d actual=%b expected=%b", tag, j, a, exp_v);
    end
  endtask

  task automatic check_inv(input int j);
    logic bad;
    bad = (pgate && (uclk || rail)) || (safe && !(pgate && ldis && eqz));
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL R10 cycle %0d actual=%b expected=no-overlap", j, act_vec());
    end
  endtask

  task automatic scenario(input int kind, input int d, input string tag);
    int horizon;
    horizon = (d > 0) ? 22 : 12;
    @(negedge clk);
    energy = (kind == 0);
    for (int j = -1; j <= horizon; j++) begin
      @(posedge clk);
      @(negedge clk);
      check_vec((j <= 0) ? "R2 latency" : tag, j, exp_at(kind, d, j));
      check_inv(j);
      if (d > 0 && j == d - 2) energy = ~energy;
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0;
    errors = 0;
    finished = 1'b0;
    rst_n  = 1'b0;
    energy = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state held while energy stays absent
    for (int k = 0; k < 4; k++) begin
      check_vec("R1 reset", k, v_off());
      @(negedge clk);
    end
    // R6/R7 plain restore
    scenario(0, 0, "R6/R7 restore");
    // R3 steady running
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check_vec("R3 run", k, v_run(1'b0));
    end
    // R4/R5 plain save
    scenario(1, 0, "R4/R5 save");
    // R8: flag drops at every offset inside a restore
    for (int d = 1; d <= 9; d++) scenario(0, d, "R8 restore-then-save");
    // back to running
    scenario(0, 0, "R6/R7 restore");
    // R9: flag returns at every offset inside a save
    for (int d = 1; d <= 9; d++) scenario(1, d, "R9 save-then-restore");
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule